// File: doc/BRIEF.md
# Sticky Event Flag and Interrupt Register Unit

This unit is the register-side control logic of a time-of-day peripheral. Five single-cycle event pulses arrive from the counting logic: update acknowledge, alarm, second tick, time event and calendar event. Each pulse latches a status flag that stays set until software clears it with a separate write-1-to-clear command. An interrupt mask is built up through a set-only register and torn down through a clear-only register, and the mask can be read back. The single interrupt line is high whenever any flag is set and its mask bit is set.

The unit also samples four "entry not valid" indicators into a read-only validity register. It holds a write-protect enable bit, and that bit changes only when a write carries the correct 24-bit key in its upper bits. Software reaches everything through a plain register port: byte address, 32-bit write data, a write strobe, and combinational read data. The reset input is asynchronous, active low, and must already be released in step with the clock.

Top module: `clkper_evt_regs`

## Requirements
- R1: Flag bit order is 0 update acknowledge, 1 alarm, 2 second, 3 time event, 4 calendar event. A high pulse on `evt_i[n]` sets flag n from the next clock edge. The flags read as bits 4:0 at offset 0x18.
- R2: A set flag stays set, over any number of idle cycles and other events, until a clear command hits it.
- R3: Writing 1 to bit n at offset 0x1C clears flag n. Bits written as 0 leave their flags unchanged.
- R4: When an event pulse and a clear command hit the same flag in the same cycle, the flag ends up set.
- R5: Writing 1s at offset 0x20 sets the matching mask bits, and writing 1s at offset 0x24 clears them. Zero bits have no effect. The mask reads as bits 4:0 at offset 0x28.
- R6: `irq_o` is high exactly when some bit is set in both the flags and the mask.
- R7: At offset 0xE4, bit 0 is the write-protect enable and bits 31:8 are the key. The enable takes wdata bit 0 only if the key equals 0x525443; a write with any other key changes nothing. Reads return the enable in bit 0 and 0 in bits 31:8.
- R8: Offset 0x2C reads the validity register: bit 0 time, bit 1 calendar, bit 2 time alarm, bit 3 calendar alarm. Each bit is `nonvalid_i` as sampled at the previous clock edge.
- R9: Writes to 0x18, 0x28 and 0x2C change nothing. Reads of unmapped offsets return 0.
- R10: After reset all flags, mask bits and the write-protect enable are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 5 | Single-cycle event pulses, flag bit order |
| nonvalid_i | input | 4 | Entry-not-valid indicators from the checking logic |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse and a clear command can hit the same flag in the same cycle. The bench provokes this by driving a time-event pulse in the same cycle as a clear write to offset 0x1C with that bit set. The flag must read back as set, and flags outside the clear mask must be untouched. A second clash, between a mask write and a newly raised flag, is judged through `irq_o`.

// File: rtl/clkper_regs_pkg.sv
package clkper_regs_pkg;
  localparam int NFLAG  = 5;
  localparam int NVLD   = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 24;

  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DIS  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_VLD  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_WP   = 8'hE4;

  localparam logic [KEY_W-1:0] WP_KEY = 24'h525443;
endpackage

// File: rtl/clkper_flag_bank.sv
// Sticky flags: a set pulse wins over a clear in the same cycle.
module clkper_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_r;
  logic [N-1:0] q_nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      q_nxt[i] = q_r[i];
      if (clr_i[i]) q_nxt[i] = 1'b0;
      if (set_i[i]) q_nxt[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    q_r[i] <= 1'b0;
      else if (set_i[i] | clr_i[i])  q_r[i] <= q_nxt[i];
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/clkper_mask_reg.sv
// Mask with set-only and clear-only write paths.
module clkper_mask_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_r;
  logic [N-1:0] q_nxt;
  logic         upd;

  always_comb begin
    q_nxt = (q_r | set_i) & ~clr_i;
    upd   = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/clkper_wprot_reg.sv
// Write-protect enable, changed only by a write carrying the key.
module clkper_wprot_reg #(
  parameter int               KEY_W = 24,
  parameter logic [KEY_W-1:0] KEY   = 24'h525443
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             en_i,
  output logic             en_o
);
  logic en_r;
  logic key_ok;

  always_comb key_ok = wr_i && (key_i == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_r <= 1'b0;
    else if (key_ok) en_r <= en_i;
  end

  assign en_o = en_r;
endmodule

// File: rtl/clkper_evt_regs.sv
module clkper_evt_regs
  import clkper_regs_pkg::*;
#(
  parameter int NF = NFLAG,
  parameter int NV = NVLD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF-1:0]     evt_i,
  input  logic [NV-1:0]     nonvalid_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int KEY_LSB = DATA_W - KEY_W;

  logic [NF-1:0] clr_cmd, ena_cmd, dis_cmd;
  logic          wp_wr;
  logic [NF-1:0] sts_q, msk_q;
  logic          wp_en_q;
  logic [NV-1:0] vld_q;

  // write decode
  always_comb begin
    clr_cmd = '0;
    ena_cmd = '0;
    dis_cmd = '0;
    wp_wr   = 1'b0;
    if (reg_wr) begin
      case (reg_addr)
        OFS_CLR: clr_cmd = reg_wdata[NF-1:0];
        OFS_ENA: ena_cmd = reg_wdata[NF-1:0];
        OFS_DIS: dis_cmd = reg_wdata[NF-1:0];
        OFS_WP:  wp_wr   = 1'b1;
        default: ;
      endcase
    end
  end

  clkper_flag_bank #(.N(NF)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_i),
    .clr_i (clr_cmd),
    .q_o   (sts_q)
  );

  clkper_mask_reg #(.N(NF)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ena_cmd),
    .clr_i (dis_cmd),
    .q_o   (msk_q)
  );

  clkper_wprot_reg #(.KEY_W(KEY_W), .KEY(WP_KEY)) u_wprot (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (wp_wr),
    .key_i (reg_wdata[DATA_W-1:KEY_LSB]),
    .en_i  (reg_wdata[0]),
    .en_o  (wp_en_q)
  );

  // validity indicators, sampled every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= nonvalid_i;
  end

  // read mux
  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = DATA_W'(sts_q);
      OFS_MASK: reg_rdata = DATA_W'(msk_q);
      OFS_VLD:  reg_rdata = DATA_W'(vld_q);
      OFS_WP:   reg_rdata = DATA_W'(wp_en_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_o = |(sts_q & msk_q);
endmodule

// File: rtl/clkper_regs_chk.sv
module clkper_regs_chk
  import clkper_regs_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NF-1:0]     evt_i,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_wr,
  input logic [NF-1:0]     sts,
  input logic [NF-1:0]     msk,
  input logic              wpen,
  input logic              irq
);
  logic [NF-1:0] clr_hit, ena_hit, dis_hit;
  logic          bad_key;

  assign clr_hit = (reg_wr && reg_addr == OFS_CLR) ? reg_wdata[NF-1:0] : '0;
  assign ena_hit = (reg_wr && reg_addr == OFS_ENA) ? reg_wdata[NF-1:0] : '0;
  assign dis_hit = (reg_wr && reg_addr == OFS_DIS) ? reg_wdata[NF-1:0] : '0;
  assign bad_key = reg_wr && reg_addr == OFS_WP &&
                   reg_wdata[DATA_W-1:DATA_W-KEY_W] != WP_KEY;

  for (genvar i = 0; i < NF; i++) begin : g_chk
    // R1 R4
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> sts[i]);
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !clr_hit[i]) |=> sts[i]);
    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && !evt_i[i]) |=> !sts[i]);
    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ena_hit[i] |=> msk[i]);
    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_hit[i] |=> !msk[i]);
    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && msk[i]) |-> irq);
  end

  // R7
  wp_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key |=> $stable(wpen));
endmodule

bind clkper_evt_regs clkper_regs_chk #(.NF(NF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_wr    (reg_wr),
  .sts       (sts_q),
  .msk       (msk_q),
  .wpen      (wp_en_q),
  .irq       (irq_o)
);

// File: tb/clkper_evt_regs_test.sv
`timescale 1ns/1ps
module clkper_evt_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  evt_i;
  logic [3:0]  nonvalid_i;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_wr;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];
  event  smp_ev;

  always #2.5 clk = ~clk;

  clkper_evt_regs uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .nonvalid_i (nonvalid_i),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .irq_o      (irq_o)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(smp_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.req = r;
    sb_q.push_back(it);
    #1 -> smp_ev;
  endtask

  task automatic expect_irq(input logic e, input string r);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.req = r;
    sb_q.push_back(it);
    #1 -> smp_ev;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; nonvalid_i = '0;
    reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    expect_rd(8'h18, 32'h0, "R10 status");
    expect_rd(8'h28, 32'h0, "R10 mask");
    expect_rd(8'hE4, 32'h0, "R10 wprot");
    expect_irq(1'b0, "R10 irq");

    // R1 bit order
    pulse(5'b00100);
    expect_rd(8'h18, 32'h04, "R1 second flag");
    pulse(5'b10001);
    expect_rd(8'h18, 32'h15, "R1 ack+cal flags");
    // R2 sticky over idle cycles
    repeat (10) @(negedge clk);
    expect_rd(8'h18, 32'h15, "R2 sticky");

    // R3 clear only written bits
    wr_reg(8'h1C, 32'h04);
    expect_rd(8'h18, 32'h11, "R3 clear second");

    // R5 / R6 mask and interrupt
    expect_irq(1'b0, "R6 masked");
    wr_reg(8'h20, 32'h01);
    expect_rd(8'h28, 32'h01, "R5 enable");
    expect_irq(1'b1, "R6 ack unmasked");
    wr_reg(8'h20, 32'h02);
    expect_rd(8'h28, 32'h03, "R5 set-only");
    wr_reg(8'h24, 32'h01);
    expect_rd(8'h28, 32'h02, "R5 disable");
    expect_irq(1'b0, "R6 no overlap");
    pulse(5'b00010);
    expect_irq(1'b1, "R6 alarm raised");

    // R4 event and clear in the same cycle
    @(negedge clk);
    evt_i = 5'b01000; reg_addr = 8'h1C; reg_wdata = 32'h08; reg_wr = 1'b1;
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0;
    expect_rd(8'h18, 32'h1B, "R4 event wins");
    wr_reg(8'h1C, 32'h1F);
    expect_rd(8'h18, 32'h00, "R3 clear all");

    // R8 validity
    nonvalid_i = 4'b1010;
    @(negedge clk);
    expect_rd(8'h2C, 32'h0A, "R8 validity");

    // R9 read-only and unmapped
    wr_reg(8'h18, 32'h1F);
    expect_rd(8'h18, 32'h00, "R9 status ro");
    wr_reg(8'h28, 32'hFF);
    expect_rd(8'h28, 32'h02, "R9 mask ro");
    wr_reg(8'h2C, 32'h05);
    expect_rd(8'h2C, 32'h0A, "R9 validity ro");
    expect_rd(8'h40, 32'h00, "R9 unmapped");

    // R7 keyed write protect
    wr_reg(8'hE4, {24'h525443, 8'h01});
    expect_rd(8'hE4, 32'h01, "R7 key accepted");
    wr_reg(8'hE4, {24'h525444, 8'h00});
    expect_rd(8'hE4, 32'h01, "R7 wrong key dropped");
    wr_reg(8'hE4, {24'h525443, 8'h00});
    expect_rd(8'hE4, 32'h00, "R7 key clears");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule